// File: doc/BRIEF.md
# LIN Slave Frame Receiver

This block receives frames from a single-wire, UART-style automotive serial bus as a slave node. It watches the already-synchronized bus level for a break: a long low interval that marks the start of every frame. It then times the sync byte that follows to learn the master's bit time, so a slave with a loose oscillator still samples correctly. Each frame is recalibrated this way.

With that bit time it receives the identifier byte and checks its two parity bits. The two length bits of the identifier set how many data bytes follow. It then collects those data bytes and a checksum byte and verifies the checksum. At the end of every frame, whether it completes or is aborted, a one-cycle strobe presents the identifier, the data bytes, the byte count and the error flags to the host logic. These values stay put until the next strobe.

Top module: `lin_frame_rx`

## Requirements
- R1: After reset, `frame_valid`, all error flags, `frame_id`, `frame_len` and `frame_data` are zero.
- R2: A frame starts only after the bus has been low for at least 13 × `NOM_BIT` clocks and then returns high. A shorter low, and any traffic that follows it, produces no strobe.
- R3: The bit time is the clock count from the first to the fifth falling edge of the sync byte (0x55), divided by 8 and rounded. Every later byte of the frame is sampled mid-bit at this rate, which is learned again in each frame.
- R4: Each byte is a low start bit, then 8 data bits with the least significant bit first, then a high stop bit.
- R5: Identifier bits 5:4 set the data length: 00 or 01 means 2 bytes, 10 means 4 bytes, 11 means 8 bytes.
- R6: Identifier bit 6 must equal id0^id1^id2^id4, and bit 7 must equal the inverse of id1^id3^id4^id5. On a mismatch the frame ends right after the identifier, with `err_parity` set, `frame_len` 0 and `frame_data` 0.
- R7: The checksum byte must equal the inverse of the 8-bit sum of the data bytes, where each carry out of bit 7 is added back into bit 0. On a mismatch `err_checksum` is set, and the data and length are still delivered.
- R8: A stop bit sampled low ends the frame at once with `err_framing` set. `frame_len` is then the number of data bytes already completed, and only those bytes appear in `frame_data`.
- R9: `frame_valid` is high for exactly one cycle per frame. All other outputs change only in that cycle.
- R10: At most one error flag is set with any strobe.
- R11: Data byte k (counting from 0) appears at `frame_data[8k+7:8k]`. Byte slots beyond `frame_len` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Synchronized bus level, high when recessive |
| frame_valid | output | 1 | One-cycle end-of-frame strobe |
| frame_id | output | 8 | Received identifier byte, including its parity bits |
| frame_len | output | 4 | Number of data bytes delivered |
| frame_data | output | 64 | Data bytes, byte 0 in the low bits |
| err_parity | output | 1 | Identifier parity mismatch |
| err_checksum | output | 1 | Checksum mismatch |
| err_framing | output | 1 | Stop bit sampled low |

## Verification
The checker module watches the strobe and its payload on every cycle. It checks that the strobe lasts one cycle and that the outputs hold between strobes. It also checks that no more than one error flag is raised, that a parity failure carries no data, and that a clean frame's length and parity agree with its identifier. Only the bench scenarios can show the rest, because each needs a serial waveform built with a known bit time: correct auto-baud across several bit rates, rejection of a short break, LSB-first byte assembly, and correct detection of bad checksums and stop bits.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

  localparam int MAX_BYTES = 8;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_ID,
    ST_DATA,
    ST_CKS
  } frame_st_t;

  // Both protection bits of the identifier must match.
  function automatic logic id_parity_ok(input logic [7:0] id);
    logic p_lo, p_hi;
    p_lo = id[0] ^ id[1] ^ id[2] ^ id[4];
    p_hi = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return (id[6] == p_lo) && (id[7] == p_hi);
  endfunction

  // Number of data bytes selected by the length field.
  function automatic logic [LEN_W-1:0] len_from_id(input logic [7:0] id);
    case (id[5:4])
      2'b10:   return LEN_W'(4);
      2'b11:   return LEN_W'(8);
      default: return LEN_W'(2);
    endcase
  endfunction

  // One step of the end-around-carry sum.
  function automatic logic [7:0] cks_add(input logic [7:0] acc, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, acc} + {1'b0, b};
    return t[7:0] + {7'd0, t[8]};
  endfunction

endpackage

// File: rtl/lin_break_det.sv
module lin_break_det #(
  parameter int CNT_W    = 16,
  parameter int BRK_CLKS = 208
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  output logic brk_done
);

  logic [CNT_W-1:0] low_cnt;
  logic             armed;

  // Count consecutive low clocks and saturate at the threshold; the break ends on the return high.
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      armed    <= 1'b0;
      brk_done <= 1'b0;
    end else begin
      brk_done <= 1'b0;
      if (!bus_in) begin
        if (low_cnt != CNT_W'(BRK_CLKS)) low_cnt <= low_cnt + 1'b1;
        if (low_cnt == CNT_W'(BRK_CLKS - 1)) armed <= 1'b1;
      end else begin
        if (armed) brk_done <= 1'b1;
        armed   <= 1'b0;
        low_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fall,
  output logic             bt_valid,
  output logic [CNT_W-1:0] bit_time
);

  logic [2:0]       edges;
  logic [CNT_W-1:0] span;

  // Measure from the first falling edge of the sync byte to its fifth: eight bit times.
  always_ff @(posedge clk) begin
    if (rst) begin
      edges    <= '0;
      span     <= '0;
      bt_valid <= 1'b0;
      bit_time <= '0;
    end else if (!en) begin
      edges    <= '0;
      span     <= '0;
      bt_valid <= 1'b0;
    end else begin
      bt_valid <= 1'b0;
      if (edges != 3'd0) span <= span + 1'b1;
      if (fall) begin
        if (edges == 3'd0) begin
          span  <= CNT_W'(1);
          edges <= 3'd1;
        end else if (edges == 3'd4) begin
          bit_time <= (span + CNT_W'(4)) >> 3;
          bt_valid <= 1'b1;
          edges    <= 3'd0;
        end else begin
          edges <= edges + 3'd1;
        end
      end
    end
  end

endmodule

// File: rtl/lin_byte_rx.sv
module lin_byte_rx #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             bus_in,
  input  logic             fall,
  input  logic [CNT_W-1:0] bit_time,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             stop_err
);

  logic             busy;
  logic [3:0]       bitn;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [7:0]       shreg;

  // bitn 0 is the start bit, 1..8 the data bits (LSB first), 9 the stop bit.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy       <= 1'b0;
      bitn       <= '0;
      cnt        <= '0;
      limit      <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      stop_err   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (!busy) begin
        if (fall) begin
          busy  <= 1'b1;
          bitn  <= '0;
          cnt   <= '0;
          limit <= (bit_time >> 1) - CNT_W'(1);
        end
      end else if (cnt == limit) begin
        cnt   <= '0;
        limit <= bit_time - CNT_W'(1);
        bitn  <= bitn + 4'd1;
        if (bitn == 4'd0) begin
          if (bus_in) busy <= 1'b0;
        end else if (bitn <= 4'd8) begin
          shreg <= {bus_in, shreg[7:1]};
        end else begin
          busy       <= 1'b0;
          byte_valid <= 1'b1;
          byte_data  <= shreg;
          stop_err   <= !bus_in;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lin_frame_rx.sv
module lin_frame_rx
  import lin_rx_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NOM_BIT = 16,
  parameter int BRK_BITS = 13
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_in,
  output logic                   frame_valid,
  output logic [7:0]             frame_id,
  output logic [LEN_W-1:0]       frame_len,
  output logic [8*MAX_BYTES-1:0] frame_data,
  output logic                   err_parity,
  output logic                   err_checksum,
  output logic                   err_framing
);

  localparam int BRK_CLKS = BRK_BITS * NOM_BIT;
  localparam int IDX_W    = $clog2(MAX_BYTES);

  frame_st_t        state;
  logic             bus_q;
  logic             fall;
  logic             brk_done;
  logic             bt_valid;
  logic [CNT_W-1:0] bit_time;
  logic             byte_valid;
  logic [7:0]       byte_data;
  logic             stop_err;
  logic             rx_en;
  logic [7:0]       id_r;
  logic [LEN_W-1:0] tgt_len;
  logic [LEN_W-1:0] byte_idx;
  logic [7:0]       sum_r;
  logic [7:0]       data_r [MAX_BYTES];
  logic [8*MAX_BYTES-1:0] data_pk;
  logic             fin, e_par, e_cks, e_frm;

  always_ff @(posedge clk) begin
    if (rst) bus_q <= 1'b1;
    else     bus_q <= bus_in;
  end
  assign fall  = bus_q & ~bus_in;
  assign rx_en = (state == ST_ID) || (state == ST_DATA) || (state == ST_CKS);

  lin_break_det #(.CNT_W(CNT_W), .BRK_CLKS(BRK_CLKS)) u_brk (
    .clk(clk), .rst(rst), .bus_in(bus_in), .brk_done(brk_done)
  );

  lin_autobaud #(.CNT_W(CNT_W)) u_baud (
    .clk(clk), .rst(rst), .en(state == ST_SYNC), .fall(fall),
    .bt_valid(bt_valid), .bit_time(bit_time)
  );

  lin_byte_rx #(.CNT_W(CNT_W)) u_byte (
    .clk(clk), .rst(rst), .en(rx_en), .bus_in(bus_in), .fall(fall),
    .bit_time(bit_time), .byte_valid(byte_valid), .byte_data(byte_data),
    .stop_err(stop_err)
  );

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_pack
    assign data_pk[8*k +: 8] = data_r[k];
  end

  // End-of-frame decision for the byte just received.
  always_comb begin
    fin = 1'b0; e_par = 1'b0; e_cks = 1'b0; e_frm = 1'b0;
    if (byte_valid) begin
      case (state)
        ST_ID: begin
          if (stop_err) begin fin = 1'b1; e_frm = 1'b1; end
          else if (!id_parity_ok(byte_data)) begin fin = 1'b1; e_par = 1'b1; end
        end
        ST_DATA: if (stop_err) begin fin = 1'b1; e_frm = 1'b1; end
        ST_CKS: begin
          fin = 1'b1;
          if (stop_err) e_frm = 1'b1;
          else if (byte_data != ~sum_r) e_cks = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      id_r         <= '0;
      tgt_len      <= '0;
      byte_idx     <= '0;
      sum_r        <= '0;
      frame_valid  <= 1'b0;
      frame_id     <= '0;
      frame_len    <= '0;
      frame_data   <= '0;
      err_parity   <= 1'b0;
      err_checksum <= 1'b0;
      err_framing  <= 1'b0;
      for (int k = 0; k < MAX_BYTES; k++) data_r[k] <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (brk_done) begin
        state <= ST_SYNC;
        for (int k = 0; k < MAX_BYTES; k++) data_r[k] <= '0;
      end else begin
        case (state)
          ST_SYNC: if (bt_valid) state <= ST_ID;
          ST_ID: if (byte_valid && !fin) begin
            id_r     <= byte_data;
            tgt_len  <= len_from_id(byte_data);
            byte_idx <= '0;
            sum_r    <= '0;
            state    <= ST_DATA;
          end
          ST_DATA: if (byte_valid && !fin) begin
            data_r[byte_idx[IDX_W-1:0]] <= byte_data;
            sum_r    <= cks_add(sum_r, byte_data);
            byte_idx <= byte_idx + 1'b1;
            if (byte_idx + 1'b1 == tgt_len) state <= ST_CKS;
          end
          default: ;
        endcase
        if (fin) begin
          state        <= ST_IDLE;
          frame_valid  <= 1'b1;
          frame_id     <= (state == ST_ID) ? byte_data : id_r;
          frame_len    <= (state == ST_ID) ? '0 : byte_idx;
          frame_data   <= data_pk;
          err_parity   <= e_par;
          err_checksum <= e_cks;
          err_framing  <= e_frm;
        end
      end
    end
  end

endmodule

// File: rtl/lin_frame_rx_chk.sv
module lin_frame_rx_chk
  import lin_rx_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   frame_valid,
  input logic [7:0]             frame_id,
  input logic [LEN_W-1:0]       frame_len,
  input logic [8*MAX_BYTES-1:0] frame_data,
  input logic                   err_parity,
  input logic                   err_checksum,
  input logic                   err_framing
);

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R9
  payload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> $stable({frame_id, frame_len, frame_data, err_parity, err_checksum, err_framing}));

  // R10
  single_err_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> $onehot0({err_parity, err_checksum, err_framing}));

  // R5
  len_field_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !err_parity && !err_framing) |-> (frame_len == len_from_id(frame_id)));

  // R6
  parity_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && err_parity) |-> (frame_len == '0 && frame_data == '0));

  // R6
  parity_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !err_parity && !err_framing) |-> id_parity_ok(frame_id));

endmodule

bind lin_frame_rx lin_frame_rx_chk u_chk (
  .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_id(frame_id),
  .frame_len(frame_len), .frame_data(frame_data), .err_parity(err_parity),
  .err_checksum(err_checksum), .err_framing(err_framing)
);

// File: tb/tb_lin_frame_rx.sv
module tb_lin_frame_rx;

  localparam int NOM = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus = 1'b1;
  logic        frame_valid;
  logic [7:0]  frame_id;
  logic [3:0]  frame_len;
  logic [63:0] frame_data;
  logic        err_parity, err_checksum, err_framing;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lin_frame_rx #(.CNT_W(16), .NOM_BIT(NOM), .BRK_BITS(13)) dut (
    .clk(clk), .rst(rst), .bus_in(bus), .frame_valid(frame_valid),
    .frame_id(frame_id), .frame_len(frame_len), .frame_data(frame_data),
    .err_parity(err_parity), .err_checksum(err_checksum), .err_framing(err_framing)
  );

  always @(negedge clk) if (!rst && frame_valid) pulses = pulses + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_id(input logic [5:0] i);
    logic p0, p1;
    p0 = i[0] ^ i[1] ^ i[2] ^ i[4];
    p1 = ~(i[1] ^ i[3] ^ i[4] ^ i[5]);
    return {p1, p0, i};
  endfunction

  function automatic int exp_len(input logic [7:0] id);
    return (id[5:4] == 2'b11) ? 8 : (id[5:4] == 2'b10) ? 4 : 2;
  endfunction

  function automatic logic [7:0] exp_cks(input logic [63:0] d, input int n);
    logic [8:0] t;
    logic [7:0] s;
    s = 8'h00;
    for (int k = 0; k < n; k++) begin
      t = {1'b0, s} + {1'b0, d[8*k +: 8]};
      s = t[7:0] + {7'd0, t[8]};
    end
    return ~s;
  endfunction

  function automatic logic [63:0] keep_bytes(input logic [63:0] d, input int n);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < n; k++) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  task automatic hold(input logic v, input int n);
    bus = v;
    repeat (n) @(negedge clk);
  endtask

  // R4: start low, data LSB first, stop, then one idle bit.
  task automatic send_byte(input logic [7:0] b, input int t, input bit stop);
    hold(1'b0, t);
    for (int k = 0; k < 8; k++) hold(b[k], t);
    hold(stop, t);
    hold(1'b1, t);
  endtask

  // bad: -1 none, 0 identifier, j = data byte j (1-based), n+1 checksum.
  task automatic send_frame(input int t, input int brk, input logic [7:0] id, input logic [63:0] d,
                            input int n, input logic [7:0] cks, input int bad);
    pulses = 0;
    hold(1'b0, brk);
    hold(1'b1, 2 * t);
    send_byte(8'h55, t, 1'b1);
    send_byte(id, t, bad != 0);
    for (int k = 0; k < n; k++) send_byte(d[8*k +: 8], t, bad != k + 1);
    send_byte(cks, t, bad != n + 1);
    hold(1'b1, 3 * t);
  endtask

  task automatic check_out(input string req, input logic [7:0] id, input int len, input logic [63:0] d,
                           input bit ep, input bit ec, input bit ef);
    chk(pulses == 1, {req, " R9 strobe count"}, 64'(pulses), 64'd1);
    chk(frame_id == id, {req, " id"}, 64'(frame_id), 64'(id));
    chk(frame_len == 4'(len), {req, " R5 len"}, 64'(frame_len), 64'(len));
    chk(frame_data == d, {req, " R11 data"}, frame_data, d);
    chk({err_parity, err_checksum, err_framing} == {ep, ec, ef}, {req, " R10 flags"},
        64'({err_parity, err_checksum, err_framing}), 64'({ep, ec, ef}));
  endtask

  task automatic good_frame(input string req, input int t, input logic [5:0] i6, input logic [63:0] draw);
    logic [7:0]  id;
    logic [63:0] d;
    int          n;
    id = mk_id(i6);
    n  = exp_len(id);
    d  = keep_bytes(draw, n);
    send_frame(t, 15 * NOM, id, d, n, exp_cks(d, n), -1);
    check_out(req, id, n, d, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    logic [7:0]  id;
    logic [63:0] d;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(frame_valid == 1'b0 && frame_len == 4'd0 && frame_id == 8'd0, "R1 reset outputs",
        64'({frame_valid, frame_len, frame_id}), 64'd0);
    chk(frame_data == 64'd0 && {err_parity, err_checksum, err_framing} == 3'b000, "R1 reset data/flags",
        frame_data, 64'd0);

    // R3 R4 slow and fast bit times, each length code
    good_frame("R3 slow 2B", 20, 6'h05, 64'h0000_0000_0000_A13C);
    good_frame("R3 fast 8B", 12, 6'h3A, 64'hF0E1_D2C3_B4A5_9687);
    good_frame("R5 4B", 16, 6'h21, 64'h0000_0000_80FF_0001);
    good_frame("R5 code01 2B", 14, 6'h17, 64'h0000_0000_0000_FFFF);

    // R2 short break: no frame
    id = mk_id(6'h05);
    d  = 64'h0000_0000_0000_1234;
    send_frame(16, 10 * NOM, id, d, 2, exp_cks(d, 2), -1);
    chk(pulses == 0, "R2 short break ignored", 64'(pulses), 64'd0);

    // R6 parity error
    id = mk_id(6'h2C) ^ 8'h40;
    d  = 64'h0000_0000_5566_7788;
    send_frame(12, 15 * NOM, id, d, 4, exp_cks(d, 4), -1);
    check_out("R6 parity", id, 0, 64'd0, 1'b1, 1'b0, 1'b0);

    // R7 checksum error, data still delivered
    id = mk_id(6'h31);
    d  = 64'h1122_3344_5566_7788;
    send_frame(18, 15 * NOM, id, d, 8, exp_cks(d, 8) ^ 8'h01, -1);
    check_out("R7 checksum", id, 8, d, 1'b0, 1'b1, 1'b0);

    // R8 framing error on second data byte
    id = mk_id(6'h10);
    d  = 64'h0000_0000_CAFE_BEEF;
    send_frame(12, 15 * NOM, id, d, 2, exp_cks(d, 2), 2);
    check_out("R8 framing data", id, 1, 64'h0000_0000_0000_00EF, 1'b0, 1'b0, 1'b1);

    // R8 framing error on identifier
    id = mk_id(6'h01);
    send_frame(12, 15 * NOM, id, d, 2, exp_cks(d, 2), 0);
    check_out("R8 framing id", id, 0, 64'd0, 1'b0, 1'b0, 1'b1);

    // R9 outputs held after the strobe
    hold(1'b1, 200);
    chk(frame_id == id && pulses == 1, "R9 hold", 64'(frame_id), 64'(id));

    // R3 random bit times, identifiers and data
    for (int r = 0; r < 8; r++) begin
      good_frame("R3 random", 12 + int'($urandom % 9), 6'($urandom), {$urandom, $urandom});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule